// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block handles the processor side of an interrupt controller that serves an 8-bit CPU. That CPU answers an interrupt by fetching a CALL instruction. The block raises its interrupt output while the priority logic reports a pending winner and no acknowledge sequence is running. It then follows the active-low acknowledge input through two pulses.

During the first pulse it drives the CALL opcode onto the data bus. It also sends one-cycle commands to the register logic: set the in-service bit of the winning level and clear that level's request bit. During the second pulse it drives one byte of the routine address. That byte is the programmed base with the winning level index inserted at bit 2, when the spacing is 4 bytes, or at bit 3, when the spacing is 8 bytes.

The level is frozen when the first pulse is taken. When the sequence finishes, the in-service bit is cleared in one of two ways. With automatic end of interrupt it is cleared at once. Otherwise it is cleared by a later end-of-interrupt strobe.

The acknowledge handshake is fixed by the processor's pulse protocol, so it has no valid/ready flow control. The block cannot push back. Every pulse is answered and every pin is a plain control or status signal. Tri-stating the bus is left to the pad: `bus_o` is held at zero whenever `bus_oe_o` is low.

Top module: `intack_vector_seq`

## Requirements
- R1: After reset, `bus_oe_o`, `bus_o`, `isr_set_o`, `irr_clr_o` and `isr_clr_o` are all zero.
- R2: `int_o` is high exactly when `req_valid_i` is high and no acknowledge sequence is in progress. A sequence runs from the cycle after the first pulse is taken until the cycle after the second pulse ends.
- R3: When `ack_n_i` falls while the block is idle and `req_valid_i` is high, the next cycle shows `isr_set_o` and `irr_clr_o` both one-hot at bit `req_level_i`. Both return to zero in the cycle after that.
- R4: From the cycle after the first acknowledge low is sampled until `ack_n_i` returns high, `bus_oe_o` is 1 and `bus_o` is the CALL opcode 8'b11001101.
- R5: During the second pulse, with the same timing as R4, `bus_o` carries the routine address byte. With `step8_i`=0, bits [4:2] hold the level and all other bits come from `base_addr_i`. With `step8_i`=1, bits [5:3] hold the level and all other bits come from `base_addr_i`.
- R6: Whenever `ack_n_i` is high, `bus_oe_o` is 0. Whenever `bus_oe_o` is 0, `bus_o` is zero.
- R7: The level used in the address byte is the one captured at the first pulse. Later changes of `req_level_i` or `req_valid_i` do not alter it.
- R8: With `auto_eoi_i`=1, the cycle after `ack_n_i` rises at the end of the second pulse shows `isr_clr_o` one-hot at the captured level, for one cycle.
- R9: With `auto_eoi_i`=0, no clear follows the second pulse. A later `eoi_i` pulse gives `isr_clr_o` one-hot at the held level in the next cycle. An `eoi_i` pulse while no level is held gives nothing.
- R10: An acknowledge pulse that begins while `req_valid_i` is low is ignored: no bus drive and no set, clear or in-service commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Priority logic reports an unmasked winner |
| req_level_i | input | 3 | Index of the winning level |
| base_addr_i | input | 8 | Programmed routine base address byte |
| step8_i | input | 1 | 1: 8-byte spacing, 0: 4-byte spacing |
| auto_eoi_i | input | 1 | Automatic end of interrupt enable |
| eoi_i | input | 1 | Explicit end-of-interrupt strobe |
| ack_n_i | input | 1 | Active-low interrupt acknowledge from the CPU |
| int_o | output | 1 | Interrupt request to the CPU |
| bus_o | output | 8 | Data byte for the CPU bus |
| bus_oe_o | output | 1 | Bus drive enable |
| isr_set_o | output | 8 | One-hot in-service set command |
| irr_clr_o | output | 8 | One-hot request clear command |
| isr_clr_o | output | 8 | One-hot in-service clear command |

## Verification
The assertions take three things for granted about the inputs. Acknowledge pulses last at least two clock cycles. The configuration inputs stay steady through a sequence. The end-of-interrupt strobe is not pulsed in the same cycle a first pulse is taken. The stimulus keeps to these by changing configuration only between sequences. It also holds each acknowledge level for two or more cycles and raises the strobe only once a sequence has completed.

// File: rtl/iavs_pkg.sv
package iavs_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_CALL = 2'd1,
    ACK_GAP  = 2'd2,
    ACK_ADDR = 2'd3
  } ack_state_e;
endpackage

// File: rtl/iavs_ack_fsm.sv
module iavs_ack_fsm
  import iavs_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_n_i,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_level_i,
  output ack_state_e       state_o,
  output logic [IDX_W-1:0] level_o,
  output logic             enter_call_o,
  output logic             leave_addr_o
);
  ack_state_e state_q, state_d;
  logic       ack_q;
  logic       ack_fall;

  assign ack_fall     = ack_q & ~ack_n_i;
  assign enter_call_o = (state_q == ACK_IDLE) & ack_fall & req_valid_i;
  assign leave_addr_o = (state_q == ACK_ADDR) & ack_n_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE: if (enter_call_o) state_d = ACK_CALL;
      ACK_CALL: if (ack_n_i)      state_d = ACK_GAP;
      ACK_GAP:  if (!ack_n_i)     state_d = ACK_ADDR;
      ACK_ADDR: if (ack_n_i)      state_d = ACK_IDLE;
      default:                    state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      ack_q   <= 1'b1;
      level_o <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_n_i;
      if (enter_call_o) level_o <= req_level_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/iavs_addr_gen.sv
module iavs_addr_gen #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int SH_N   = 2,
  parameter int SH_W   = 3
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [IDX_W-1:0]  level_i,
  input  logic              step8_i,
  output logic [DATA_W-1:0] addr_o
);
  logic [DATA_W-1:0] narrow, wide;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= SH_N && b < SH_N + IDX_W) begin : g_n_lvl
      assign narrow[b] = level_i[b-SH_N];
    end else begin : g_n_base
      assign narrow[b] = base_i[b];
    end
    if (b >= SH_W && b < SH_W + IDX_W) begin : g_w_lvl
      assign wide[b] = level_i[b-SH_W];
    end else begin : g_w_base
      assign wide[b] = base_i[b];
    end
  end

  assign addr_o = step8_i ? wide : narrow;
endmodule

// File: rtl/iavs_svc_cmd.sv
module iavs_svc_cmd #(
  parameter int N_LEVELS = 8,
  localparam int IDX_W   = $clog2(N_LEVELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enter_call_i,
  input  logic [IDX_W-1:0]    req_level_i,
  input  logic                leave_addr_i,
  input  logic                auto_eoi_i,
  input  logic                eoi_i,
  output logic [N_LEVELS-1:0] isr_set_o,
  output logic [N_LEVELS-1:0] irr_clr_o,
  output logic [N_LEVELS-1:0] isr_clr_o
);
  logic             held_v;
  logic [IDX_W-1:0] held_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_set_o <= '0;
      irr_clr_o <= '0;
      isr_clr_o <= '0;
      held_v    <= 1'b0;
      held_idx  <= '0;
    end else begin
      isr_set_o <= '0;
      irr_clr_o <= '0;
      isr_clr_o <= '0;
      if (held_v && ((leave_addr_i && auto_eoi_i) || eoi_i)) begin
        isr_clr_o <= N_LEVELS'(1) << held_idx;
        held_v    <= 1'b0;
      end
      if (enter_call_i) begin
        isr_set_o <= N_LEVELS'(1) << req_level_i;
        irr_clr_o <= N_LEVELS'(1) << req_level_i;
        held_v    <= 1'b1;
        held_idx  <= req_level_i;
      end
    end
  end
endmodule

// File: rtl/intack_vector_seq.sv
module intack_vector_seq
  import iavs_pkg::*;
#(
  parameter int N_LEVELS = 8,
  parameter int DATA_W   = 8,
  parameter logic [7:0] CALL_OP = 8'b11001101,
  localparam int IDX_W   = $clog2(N_LEVELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic [IDX_W-1:0]    req_level_i,
  input  logic [DATA_W-1:0]   base_addr_i,
  input  logic                step8_i,
  input  logic                auto_eoi_i,
  input  logic                eoi_i,
  input  logic                ack_n_i,
  output logic                int_o,
  output logic [DATA_W-1:0]   bus_o,
  output logic                bus_oe_o,
  output logic [N_LEVELS-1:0] isr_set_o,
  output logic [N_LEVELS-1:0] irr_clr_o,
  output logic [N_LEVELS-1:0] isr_clr_o
);
  ack_state_e        state;
  logic [IDX_W-1:0]  level_q;
  logic              enter_call, leave_addr;
  logic [DATA_W-1:0] addr_byte;

  iavs_ack_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ack_n_i(ack_n_i),
    .req_valid_i(req_valid_i), .req_level_i(req_level_i),
    .state_o(state), .level_o(level_q),
    .enter_call_o(enter_call), .leave_addr_o(leave_addr)
  );

  iavs_addr_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SH_N(2), .SH_W(3)) u_addr (
    .base_i(base_addr_i), .level_i(level_q), .step8_i(step8_i),
    .addr_o(addr_byte)
  );

  iavs_svc_cmd #(.N_LEVELS(N_LEVELS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .enter_call_i(enter_call),
    .req_level_i(req_level_i), .leave_addr_i(leave_addr),
    .auto_eoi_i(auto_eoi_i), .eoi_i(eoi_i),
    .isr_set_o(isr_set_o), .irr_clr_o(irr_clr_o), .isr_clr_o(isr_clr_o)
  );

  assign int_o    = req_valid_i & (state == ACK_IDLE);
  assign bus_oe_o = ~ack_n_i & ((state == ACK_CALL) | (state == ACK_ADDR));
  assign bus_o    = !bus_oe_o ? '0 :
                    (state == ACK_CALL) ? DATA_W'(CALL_OP) : addr_byte;
endmodule

// File: rtl/iavs_chk.sv
module iavs_chk #(
  parameter int N_LEVELS = 8,
  parameter int DATA_W   = 8,
  parameter logic [7:0] CALL_OP = 8'b11001101,
  localparam int IDX_W   = $clog2(N_LEVELS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid_i,
  input logic [IDX_W-1:0]    req_level_i,
  input logic [DATA_W-1:0]   base_addr_i,
  input logic                step8_i,
  input logic                auto_eoi_i,
  input logic                eoi_i,
  input logic                ack_n_i,
  input logic                int_o,
  input logic [DATA_W-1:0]   bus_o,
  input logic                bus_oe_o,
  input logic [N_LEVELS-1:0] isr_set_o,
  input logic [N_LEVELS-1:0] irr_clr_o,
  input logic [N_LEVELS-1:0] isr_clr_o
);
  p_oe_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> !ack_n_i);
  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> (bus_o == '0));
  p_int_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |-> !int_o);
  p_set_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_set_o) && (isr_set_o == irr_clr_o));
  p_set_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|isr_set_o) |=> (isr_set_o == '0));
  p_set_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|isr_set_o) |-> $past(!ack_n_i));
  p_call_opcode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|isr_set_o) && !ack_n_i) |-> (bus_oe_o && bus_o == DATA_W'(CALL_OP)));
  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr_o));
  p_no_int_in_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|isr_set_o) |-> !int_o);
endmodule

bind intack_vector_seq iavs_chk #(
  .N_LEVELS(N_LEVELS), .DATA_W(DATA_W), .CALL_OP(CALL_OP)
) u_chk (.*);

// File: tb/test_intack_vector_seq.sv
module test_intack_vector_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [2:0] req_level_i = '0;
  logic [7:0] base_addr_i = '0;
  logic       step8_i = 1'b0;
  logic       auto_eoi_i = 1'b0;
  logic       eoi_i = 1'b0;
  logic       ack_n_i = 1'b1;
  logic       int_o, bus_oe_o;
  logic [7:0] bus_o, isr_set_o, irr_clr_o, isr_clr_o;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intack_vector_seq i_intack_vector_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input int base, input int lvl, input bit s8);
    if (s8) return 8'((base / 64) * 64 + lvl * 8 + base % 8);
    return 8'((base / 32) * 32 + lvl * 4 + base % 4);
  endfunction

  task automatic run_seq(input int lvl, input int late, input int base,
                         input bit s8, input bit ae);
    logic [7:0] oh = 8'(1) << lvl;
    @(negedge clk);
    req_valid_i = 1'b1; req_level_i = 3'(lvl);
    base_addr_i = 8'(base); step8_i = s8; auto_eoi_i = ae;
    @(negedge clk);
    chk("R2 int", {31'd0, int_o}, 1);
    ack_n_i = 1'b0;
    @(negedge clk);
    chk("R3 set", {24'd0, isr_set_o}, {24'd0, oh});
    chk("R3 clr", {24'd0, irr_clr_o}, {24'd0, oh});
    chk("R4 call", {23'd0, bus_oe_o, bus_o}, {23'd0, 1'b1, 8'hCD});
    chk("R2 busy", {31'd0, int_o}, 0);
    req_level_i = 3'(late); req_valid_i = 1'b0;
    @(negedge clk);
    chk("R3 single", {24'd0, isr_set_o}, 0);
    ack_n_i = 1'b1; #1;
    chk("R6 gap", {23'd0, bus_oe_o, bus_o}, 0);
    req_valid_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ack_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 R7 addr", {23'd0, bus_oe_o, bus_o}, {23'd0, 1'b1, exp_addr(base, lvl, s8)});
    ack_n_i = 1'b1; #1;
    chk("R6 end", {23'd0, bus_oe_o, bus_o}, 0);
    req_valid_i = 1'b0;
    @(negedge clk);
    if (ae) begin
      chk("R8 auto clr", {24'd0, isr_clr_o}, {24'd0, oh});
    end else begin
      chk("R9 no auto clr", {24'd0, isr_clr_o}, 0);
      eoi_i = 1'b1;
      @(negedge clk);
      eoi_i = 1'b0;
      chk("R9 eoi clr", {24'd0, isr_clr_o}, {24'd0, oh});
    end
    @(negedge clk);
    chk("R8 R9 one pulse", {24'd0, isr_clr_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {7'd0, bus_oe_o, bus_o, isr_set_o, irr_clr_o},
        0);
    chk("R1 reset iclr", {24'd0, isr_clr_o}, 0);
    // R10: acknowledge with nothing pending
    ack_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 ignore", {15'd0, bus_oe_o, isr_set_o, irr_clr_o}, 0);
    ack_n_i = 1'b1;
    @(negedge clk);
    chk("R10 int", {31'd0, int_o}, 0);
    // R9: strobe with nothing held
    eoi_i = 1'b1;
    @(negedge clk);
    eoi_i = 1'b0;
    chk("R9 idle eoi", {24'd0, isr_clr_o}, 0);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 2; a++)
        for (int bi = 0; bi < 4; bi++)
          for (int l = 0; l < 8; l++) begin
            int bases[4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
            run_seq(l, 7 - l, bases[bi], s[0], a[0]);
          end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule